// File: doc/BRIEF.md
# SMBus Slave System-Command Decoder

This block is an SMBus slave that an external management controller uses to send short Byte Write transactions into the system. It oversamples SCL and SDA with the core clock, finds START and STOP conditions, and receives an address byte, a register index byte and a data byte. It acknowledges the index and data bytes only when the address byte carries its own 7-bit address with the write direction. It answers by pulling SDA low through an open-drain enable.

The register index selects one of three targets. Index 0x00 is a command register, and the value written there is decoded into a system action. Index 0x04 and index 0x05 are two message bytes that each write simply overwrites. Every other index is reserved and ignored.

Command codes raise single-cycle request pulses: wake or SMI, power-button override, warm or cold hard reset, and watchdog reload. Two status bits record wake and override events until software clears them. A sticky flag that silences heartbeat and event messages can be cleared only by the resume-well reset.

Top module: `smb_cmd_slave`

## Requirements
- R1: The block drives SDA low for an address acknowledge only when the 7 address bits equal `SLV_ADDR` and the direction bit (eighth bit) is 0. For any other address byte, `sda_oe` stays 0 until the next START, and the frame changes no output.
- R2: In a matched write frame, the index byte and the data byte are both acknowledged. Any byte sent after the data byte is not acknowledged.
- R3: A write to index 0x04 loads `msg_byte0`, and a write to index 0x05 loads `msg_byte1`. Each write replaces the previous value unconditionally.
- R4: A write to any index other than 0x00, 0x04 or 0x05 changes no register and raises no pulse.
- R5: Writing command code 0x01 to index 0x00 raises `wake_pulse` when `sys_awake` is 0, or `smi_pulse` when `sys_awake` is 1. In both cases `wake_sts` is set and stays set until `wake_sts_clr` is applied.
- R6: Command code 0x02 raises `pbo_pulse` and sets `pbo_sts`, which stays set until `pbo_sts_clr` is applied.
- R7: Command code 0x03 puts 3'b011 on `rst_ctl_bits` for one cycle (warm reset: bits 2:1 set, bit 3 clear). Command code 0x04 puts 3'b111 there for one cycle (cold reset). Output bit 0 stands for control bit 1.
- R8: Command code 0x05 sets `msg_disable`. The flag survives `rst_n` and is cleared only by asserting `rsm_rst_n` low.
- R9: Command code 0x06 raises `wdt_reload`. Codes 0x00, 0x07 and all other values raise nothing, but are still stored in `cmd_reg`, which always holds the last value written to index 0x00.
- R10: A matched write raises at most one action, lasting exactly one clock. It appears only after the data byte has been acknowledged, so a frame cut short before that point has no effect.
- R11: A START seen in the middle of a frame discards the partial frame and restarts address reception.
- R12: After `rst_n`, all registers, pulses and status bits are 0 and `sda_oe` is 0. After `rsm_rst_n`, `msg_disable` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low core reset |
| rsm_rst_n | input | 1 | Active-low resume-well reset, the only clear for `msg_disable` |
| scl_i | input | 1 | SMBus clock line level |
| sda_i | input | 1 | SMBus data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| sys_awake | input | 1 | 1 when the system is running |
| wake_sts_clr | input | 1 | Clears `wake_sts` |
| pbo_sts_clr | input | 1 | Clears `pbo_sts` |
| cmd_reg | output | 8 | Last value written to index 0x00 |
| msg_byte0 | output | 8 | Message byte at index 0x04 |
| msg_byte1 | output | 8 | Message byte at index 0x05 |
| wake_pulse | output | 1 | Wake request, one cycle |
| smi_pulse | output | 1 | SMI request, one cycle |
| pbo_pulse | output | 1 | Power-button override request, one cycle |
| rst_ctl_bits | output | 3 | Hard-reset control bits 3:1, non-zero for one cycle |
| wdt_reload | output | 1 | Watchdog reload, one cycle |
| wake_sts | output | 1 | Sticky wake status |
| pbo_sts | output | 1 | Sticky override status |
| msg_disable | output | 1 | Sticky message-disable flag |

## Verification
The bench aims at the wake/SMI split on `sys_awake`. A design that ignores the awake input would raise the wrong pulse, and the pulse counts would mismatch. It sends foreign addresses and read-direction bytes; a slave that acknowledged them or stored their data would show a stray ACK, an `sda_oe` assertion, or a changed byte. It cuts frames short with a repeated START part-way through the data byte. A design that acted on partial data, or failed to resynchronise on the START, would corrupt a message byte or miss the following write. It pulses the core reset after a disable command, so a flag wired to the wrong reset is exposed. It also sends a surplus byte after the data byte, which a design that kept acknowledging would answer.

// File: rtl/smb_cmd_pkg.sv
package smb_cmd_pkg;

   localparam int unsigned BYTE_BITS = 8;

   localparam logic [7:0] IDX_CMD  = 8'h00;
   localparam logic [7:0] IDX_MSG0 = 8'h04;
   localparam logic [7:0] IDX_MSG1 = 8'h05;

   localparam logic [7:0] CODE_WAKE = 8'h01;
   localparam logic [7:0] CODE_PBO  = 8'h02;
   localparam logic [7:0] CODE_WARM = 8'h03;
   localparam logic [7:0] CODE_COLD = 8'h04;
   localparam logic [7:0] CODE_MOFF = 8'h05;
   localparam logic [7:0] CODE_WDT  = 8'h06;

   typedef enum logic [2:0] {
      ST_IDLE, ST_ADDR, ST_ACK_A, ST_CMD, ST_ACK_C, ST_DATA, ST_ACK_D, ST_SKIP
   } frame_st_e;

   typedef struct packed {
      logic wake;
      logic smi;
      logic pbo;
      logic rst_warm;
      logic rst_cold;
      logic msg_off;
      logic wdt;
   } act_t;

   function automatic act_t decode_cmd(input logic [7:0] code, input logic awake);
      act_t a;
      a = '0;
      unique case (code)
         CODE_WAKE: begin
            a.smi  = awake;
            a.wake = !awake;
         end
         CODE_PBO:  a.pbo      = 1'b1;
         CODE_WARM: a.rst_warm = 1'b1;
         CODE_COLD: a.rst_cold = 1'b1;
         CODE_MOFF: a.msg_off  = 1'b1;
         CODE_WDT:  a.wdt      = 1'b1;
         default:   a = '0;
      endcase
      return a;
   endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic [STAGES-1:0] scl_sh, sda_sh;
   logic              scl_d, sda_d;
   logic              scl_now;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_sh <= '1;
         sda_sh <= '1;
         scl_d  <= 1'b1;
         sda_d  <= 1'b1;
      end else begin
         scl_sh <= {scl_sh[STAGES-2:0], scl_i};
         sda_sh <= {sda_sh[STAGES-2:0], sda_i};
         scl_d  <= scl_sh[STAGES-1];
         sda_d  <= sda_sh[STAGES-1];
      end
   end

   assign scl_now   = scl_sh[STAGES-1];
   assign sda_lvl   = sda_sh[STAGES-1];
   assign scl_rise  = scl_now & ~scl_d;
   assign scl_fall  = ~scl_now & scl_d;
   assign start_det = scl_now & scl_d & sda_d & ~sda_lvl;
   assign stop_det  = scl_now & scl_d & ~sda_d & sda_lvl;

endmodule

// File: rtl/smb_frame_rx.sv
module smb_frame_rx
   import smb_cmd_pkg::*;
#(
   parameter logic [6:0] SLV_ADDR = 7'h2A
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sda_lvl,
   input  logic       scl_rise,
   input  logic       scl_fall,
   input  logic       start_det,
   input  logic       stop_det,
   output logic       sda_oe,
   output logic       wr_stb,
   output logic [7:0] wr_idx,
   output logic [7:0] wr_data
);
   localparam int unsigned CNT_W = $clog2(BYTE_BITS + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_BITS);

   frame_st_e        state;
   logic [CNT_W-1:0] bit_cnt;
   logic [7:0]       shreg;
   logic             addr_hit;

   assign addr_hit = (shreg[7:1] == SLV_ADDR) && !shreg[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         bit_cnt <= '0;
         shreg   <= '0;
         sda_oe  <= 1'b0;
         wr_stb  <= 1'b0;
         wr_idx  <= '0;
         wr_data <= '0;
      end else begin
         wr_stb <= 1'b0;
         if (stop_det) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
         end else if (start_det) begin
            state   <= ST_ADDR;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
         end else begin
            unique case (state)
               ST_ADDR, ST_CMD, ST_DATA: begin
                  if (scl_rise && bit_cnt < CNT_FULL) begin
                     shreg   <= {shreg[6:0], sda_lvl};
                     bit_cnt <= bit_cnt + 1'b1;
                  end else if (scl_fall && bit_cnt == CNT_FULL) begin
                     bit_cnt <= '0;
                     if (state == ST_ADDR) begin
                        state  <= addr_hit ? ST_ACK_A : ST_SKIP;
                        sda_oe <= addr_hit;
                     end else if (state == ST_CMD) begin
                        wr_idx <= shreg;
                        state  <= ST_ACK_C;
                        sda_oe <= 1'b1;
                     end else begin
                        wr_data <= shreg;
                        state   <= ST_ACK_D;
                        sda_oe  <= 1'b1;
                     end
                  end
               end
               ST_ACK_A, ST_ACK_C, ST_ACK_D: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b0;
                     if (state == ST_ACK_A)      state <= ST_CMD;
                     else if (state == ST_ACK_C) state <= ST_DATA;
                     else begin
                        state  <= ST_SKIP;
                        wr_stb <= 1'b1;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/smb_cmd_regs.sv
module smb_cmd_regs
   import smb_cmd_pkg::*;
#(
   parameter bit STS_SET_WINS = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rsm_rst_n,
   input  logic       wr_stb,
   input  logic [7:0] wr_idx,
   input  logic [7:0] wr_data,
   input  logic       sys_awake,
   input  logic       wake_sts_clr,
   input  logic       pbo_sts_clr,
   output logic [7:0] cmd_reg,
   output logic [7:0] msg_byte0,
   output logic [7:0] msg_byte1,
   output logic       wake_pulse,
   output logic       smi_pulse,
   output logic       pbo_pulse,
   output logic [2:0] rst_ctl_bits,
   output logic       wdt_reload,
   output logic       wake_sts,
   output logic       pbo_sts,
   output logic       msg_disable
);
   localparam int unsigned N_STS = 2;

   act_t             dec, act_q;
   logic             cmd_wr;
   logic [N_STS-1:0] sts_q, sts_set, sts_clr;

   assign cmd_wr = wr_stb && (wr_idx == IDX_CMD);
   assign dec    = cmd_wr ? decode_cmd(wr_data, sys_awake) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q     <= '0;
         cmd_reg   <= '0;
         msg_byte0 <= '0;
         msg_byte1 <= '0;
      end else begin
         act_q <= dec;
         if (cmd_wr) cmd_reg <= wr_data;
         if (wr_stb && wr_idx == IDX_MSG0) msg_byte0 <= wr_data;
         if (wr_stb && wr_idx == IDX_MSG1) msg_byte1 <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rsm_rst_n) begin
      if (!rsm_rst_n)         msg_disable <= 1'b0;
      else if (act_q.msg_off) msg_disable <= 1'b1;
   end

   assign sts_set = {dec.pbo, dec.wake | dec.smi};
   assign sts_clr = {pbo_sts_clr, wake_sts_clr};

   for (genvar g = 0; g < N_STS; g++) begin : g_sts
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sts_q[g] <= 1'b0;
         else if (STS_SET_WINS) sts_q[g] <= sts_set[g] | (sts_q[g] & ~sts_clr[g]);
         else                   sts_q[g] <= (sts_q[g] | sts_set[g]) & ~sts_clr[g];
      end
   end

   assign wake_sts     = sts_q[0];
   assign pbo_sts      = sts_q[1];
   assign wake_pulse   = act_q.wake;
   assign smi_pulse    = act_q.smi;
   assign pbo_pulse    = act_q.pbo;
   assign wdt_reload   = act_q.wdt;
   assign rst_ctl_bits = act_q.rst_cold ? 3'b111 : (act_q.rst_warm ? 3'b011 : 3'b000);

endmodule

// File: rtl/smb_cmd_slave.sv
module smb_cmd_slave #(
   parameter logic [6:0]  SLV_ADDR     = 7'h2A,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter bit          STS_SET_WINS = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rsm_rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_oe,
   input  logic       sys_awake,
   input  logic       wake_sts_clr,
   input  logic       pbo_sts_clr,
   output logic [7:0] cmd_reg,
   output logic [7:0] msg_byte0,
   output logic [7:0] msg_byte1,
   output logic       wake_pulse,
   output logic       smi_pulse,
   output logic       pbo_pulse,
   output logic [2:0] rst_ctl_bits,
   output logic       wdt_reload,
   output logic       wake_sts,
   output logic       pbo_sts,
   output logic       msg_disable
);
   if (SYNC_STAGES < 2 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES must be 2..4");
   end
   if (SLV_ADDR < 7'h08 || SLV_ADDR > 7'h77) begin : g_bad_addr
      $error("SLV_ADDR lies in a reserved address range");
   end

   logic       sda_lvl, scl_rise, scl_fall, start_det, stop_det;
   logic       wr_stb;
   logic [7:0] wr_idx, wr_data;

   smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   smb_frame_rx #(.SLV_ADDR(SLV_ADDR)) u_frame (
      .clk(clk), .rst_n(rst_n), .sda_lvl(sda_lvl),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det),
      .sda_oe(sda_oe), .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_data(wr_data)
   );

   smb_cmd_regs #(.STS_SET_WINS(STS_SET_WINS)) u_regs (
      .clk(clk), .rst_n(rst_n), .rsm_rst_n(rsm_rst_n),
      .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_data(wr_data),
      .sys_awake(sys_awake), .wake_sts_clr(wake_sts_clr), .pbo_sts_clr(pbo_sts_clr),
      .cmd_reg(cmd_reg), .msg_byte0(msg_byte0), .msg_byte1(msg_byte1),
      .wake_pulse(wake_pulse), .smi_pulse(smi_pulse), .pbo_pulse(pbo_pulse),
      .rst_ctl_bits(rst_ctl_bits), .wdt_reload(wdt_reload),
      .wake_sts(wake_sts), .pbo_sts(pbo_sts), .msg_disable(msg_disable)
   );

endmodule

// File: rtl/smb_cmd_chk.sv
module smb_cmd_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       rsm_rst_n,
   input logic       scl_i,
   input logic       sda_oe,
   input logic       sys_awake,
   input logic       wr_stb,
   input logic       wake_pulse,
   input logic       smi_pulse,
   input logic       pbo_pulse,
   input logic [2:0] rst_ctl_bits,
   input logic       wdt_reload,
   input logic       wake_sts,
   input logic       msg_disable
);
   logic any_act;
   assign any_act = wake_pulse | smi_pulse | pbo_pulse | wdt_reload | (|rst_ctl_bits);

   // R1
   sda_edge_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != $past(sda_oe)) |-> !scl_i);

   // R10
   single_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wake_pulse, smi_pulse, pbo_pulse, wdt_reload, |rst_ctl_bits}));

   // R10
   action_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_act |-> $past(wr_stb));

   // R10
   pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_act |=> !any_act);

   // R5
   wake_when_asleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |-> !$past(sys_awake));

   // R5
   smi_when_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      smi_pulse |-> $past(sys_awake));

   // R5
   wake_sts_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wake_sts) |-> $past(wr_stb));

   // R8
   msg_disable_sticky_chk: assert property (@(posedge clk) disable iff (!rsm_rst_n)
      $past(msg_disable) |-> msg_disable);

   // R7
   rst_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|rst_ctl_bits) |-> rst_ctl_bits[1] && rst_ctl_bits[0]);

endmodule

bind smb_cmd_slave smb_cmd_chk i_chk (
   .clk(clk), .rst_n(rst_n), .rsm_rst_n(rsm_rst_n), .scl_i(scl_i),
   .sda_oe(sda_oe), .sys_awake(sys_awake), .wr_stb(wr_stb),
   .wake_pulse(wake_pulse), .smi_pulse(smi_pulse), .pbo_pulse(pbo_pulse),
   .rst_ctl_bits(rst_ctl_bits), .wdt_reload(wdt_reload),
   .wake_sts(wake_sts), .msg_disable(msg_disable)
);

// File: tb/test_smb_cmd_slave.sv
module test_smb_cmd_slave;
   localparam logic [6:0] ADDR = 7'h2A;
   localparam int Q = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0, rsm_rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic sys_awake = 1'b0, wake_sts_clr = 1'b0, pbo_sts_clr = 1'b0;
   logic sda_oe, sda_line;
   logic [7:0] cmd_reg, msg_byte0, msg_byte1;
   logic wake_pulse, smi_pulse, pbo_pulse, wdt_reload, wake_sts, pbo_sts, msg_disable;
   logic [2:0] rst_ctl_bits;

   int n_cmp = 0, n_mis = 0;
   int c_wake = 0, c_smi = 0, c_pbo = 0, c_warm = 0, c_cold = 0, c_wdt = 0, c_bad = 0;
   int e_wake = 0, e_smi = 0, e_pbo = 0, e_warm = 0, e_cold = 0, e_wdt = 0;
   logic [7:0] e_cmd = 0, e_b0 = 0, e_b1 = 0;
   logic e_wsts = 0, e_psts = 0, e_dis = 0;
   logic oe_seen = 0;

   always #4 clk = ~clk;

   assign sda_line = sda_m & ~sda_oe;

   smb_cmd_slave #(.SLV_ADDR(ADDR)) i_smb_cmd_slave (
      .clk(clk), .rst_n(rst_n), .rsm_rst_n(rsm_rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_oe(sda_oe), .sys_awake(sys_awake), .wake_sts_clr(wake_sts_clr),
      .pbo_sts_clr(pbo_sts_clr), .cmd_reg(cmd_reg), .msg_byte0(msg_byte0),
      .msg_byte1(msg_byte1), .wake_pulse(wake_pulse), .smi_pulse(smi_pulse),
      .pbo_pulse(pbo_pulse), .rst_ctl_bits(rst_ctl_bits), .wdt_reload(wdt_reload),
      .wake_sts(wake_sts), .pbo_sts(pbo_sts), .msg_disable(msg_disable)
   );

   always @(negedge clk) begin
      if (wake_pulse) c_wake++;
      if (smi_pulse)  c_smi++;
      if (pbo_pulse)  c_pbo++;
      if (wdt_reload) c_wdt++;
      if (rst_ctl_bits == 3'b011) c_warm++;
      else if (rst_ctl_bits == 3'b111) c_cold++;
      else if (rst_ctl_bits != 3'b000) c_bad++;
      if (sda_oe) oe_seen = 1'b1;
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_mis++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_start();
      sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
      sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
   endtask

   task automatic put_bit(input logic b);
      sda_m = b; tick(Q); scl_m = 1'b1; tick(2 * Q); scl_m = 1'b0; tick(Q);
   endtask

   task automatic put_byte(input logic [7:0] b);
      for (int i = 7; i >= 0; i--) put_bit(b[i]);
   endtask

   task automatic get_ack(output logic acked);
      sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
      acked = (sda_line == 1'b0);
      tick(Q); scl_m = 1'b0; tick(Q);
   endtask

   task automatic write_frame(input logic [6:0] a, input logic rw, input logic [7:0] idx,
                              input logic [7:0] dat, output logic aa, output logic ac,
                              output logic ad);
      bus_start();
      put_byte({a, rw}); get_ack(aa);
      put_byte(idx);     get_ack(ac);
      put_byte(dat);     get_ack(ad);
      bus_stop();
      tick(8);
   endtask

   // Bench model of a write that reaches the register block
   task automatic model_write(input logic [7:0] idx, input logic [7:0] dat, input logic awake);
      if (idx == 8'h00) begin
         e_cmd = dat;
         case (dat)
            8'h01: begin if (awake) e_smi++; else e_wake++; e_wsts = 1'b1; end
            8'h02: begin e_pbo++; e_psts = 1'b1; end
            8'h03: e_warm++;
            8'h04: e_cold++;
            8'h05: e_dis = 1'b1;
            8'h06: e_wdt++;
            default: ;
         endcase
      end else if (idx == 8'h04) e_b0 = dat;
      else if (idx == 8'h05) e_b1 = dat;
   endtask

   task automatic check_all();
      chk("R3 msg_byte0", msg_byte0, e_b0);
      chk("R3 msg_byte1", msg_byte1, e_b1);
      chk("R9 cmd_reg", cmd_reg, e_cmd);
      chk("R5 wake count", c_wake, e_wake);
      chk("R5 smi count", c_smi, e_smi);
      chk("R5 wake_sts", wake_sts, e_wsts);
      chk("R6 pbo count", c_pbo, e_pbo);
      chk("R6 pbo_sts", pbo_sts, e_psts);
      chk("R7 warm count", c_warm, e_warm);
      chk("R7 cold count", c_cold, e_cold);
      chk("R8 msg_disable", msg_disable, e_dis);
      chk("R9 wdt count", c_wdt, e_wdt);
      chk("R10 illegal rst code count", c_bad, 0);
   endtask

   task automatic good_write(input string req, input logic [7:0] idx, input logic [7:0] dat);
      logic aa, ac, ad;
      write_frame(ADDR, 1'b0, idx, dat, aa, ac, ad);
      model_write(idx, dat, sys_awake);
      chk({req, " R2 acks"}, {aa, ac, ad}, 3'b111);
      check_all();
   endtask

   task automatic clear_sts();
      wake_sts_clr = 1'b1; pbo_sts_clr = 1'b1; tick(1);
      wake_sts_clr = 1'b0; pbo_sts_clr = 1'b0; tick(1);
      e_wsts = 1'b0; e_psts = 1'b0;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_mis++;
      $display("FAIL R12 watchdog actual=timeout expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
      $finish;
   end

   initial begin
      logic aa, ac, ad;
      void'($urandom(32'd20240611));
      tick(10);
      rst_n = 1'b1; rsm_rst_n = 1'b1;
      tick(5);

      // R12 reset state
      chk("R12 sda_oe", sda_oe, 0);
      chk("R12 regs", {cmd_reg, msg_byte0, msg_byte1}, 0);
      chk("R12 flags", {wake_sts, pbo_sts, msg_disable, rst_ctl_bits}, 0);

      // R3 data bytes and overwrite
      good_write("R3", 8'h04, 8'hA5);
      good_write("R3", 8'h05, 8'h3C);
      good_write("R3 overwrite", 8'h04, 8'h17);

      // R4 reserved indices
      good_write("R4", 8'h01, 8'h55);
      good_write("R4", 8'h09, 8'h01);
      good_write("R4", 8'hFF, 8'h06);

      // R5 wake vs SMI
      sys_awake = 1'b0; good_write("R5 asleep", 8'h00, 8'h01);
      sys_awake = 1'b1; good_write("R5 awake", 8'h00, 8'h01);
      clear_sts();
      chk("R5 wake_sts cleared", wake_sts, 0);

      // R6, R7, R9
      good_write("R6", 8'h00, 8'h02);
      clear_sts();
      chk("R6 pbo_sts cleared", pbo_sts, 0);
      good_write("R7 warm", 8'h00, 8'h03);
      good_write("R7 cold", 8'h00, 8'h04);
      good_write("R9 wdt", 8'h00, 8'h06);
      good_write("R9 reserved 0", 8'h00, 8'h00);
      good_write("R9 reserved 7", 8'h00, 8'h07);
      good_write("R9 reserved FF", 8'h00, 8'hFF);

      // R1 foreign address and read direction
      oe_seen = 1'b0;
      write_frame(ADDR ^ 7'h01, 1'b0, 8'h04, 8'hEE, aa, ac, ad);
      chk("R1 foreign addr acks", {aa, ac, ad}, 3'b000);
      chk("R1 foreign addr sda_oe", oe_seen, 0);
      write_frame(ADDR, 1'b1, 8'h00, 8'h06, aa, ac, ad);
      chk("R1 read dir acks", {aa, ac, ad}, 3'b000);
      check_all();

      // R2 surplus byte not acknowledged
      bus_start();
      put_byte({ADDR, 1'b0}); get_ack(aa);
      put_byte(8'h05);        get_ack(ac);
      put_byte(8'h99);        get_ack(ad);
      put_byte(8'h42);        get_ack(aa);
      bus_stop(); tick(8);
      model_write(8'h05, 8'h99, sys_awake);
      chk("R2 surplus byte nack", aa, 0);
      check_all();

      // R11/R10 repeated START inside data byte
      bus_start();
      put_byte({ADDR, 1'b0}); get_ack(aa);
      put_byte(8'h04);        get_ack(ac);
      put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
      bus_start();
      put_byte({ADDR, 1'b0}); get_ack(aa);
      chk("R11 restart addr ack", aa, 1);
      put_byte(8'h00);        get_ack(ac);
      put_byte(8'h06);        get_ack(ad);
      bus_stop(); tick(8);
      model_write(8'h00, 8'h06, sys_awake);
      chk("R10 partial frame no effect", msg_byte0, e_b0);
      check_all();

      // R8 disable flag vs resets
      good_write("R8", 8'h00, 8'h05);
      rst_n = 1'b0; tick(3); rst_n = 1'b1; tick(3);
      e_cmd = 0; e_b0 = 0; e_b1 = 0; e_wsts = 0; e_psts = 0;
      chk("R8 survives core reset", msg_disable, 1);
      chk("R12 core reset regs", {cmd_reg, msg_byte0, msg_byte1}, 0);
      rsm_rst_n = 1'b0; tick(3); rsm_rst_n = 1'b1; tick(3);
      e_dis = 1'b0;
      chk("R8 cleared by resume reset", msg_disable, 0);

      // Random mix
      for (int it = 0; it < 50; it++) begin
         logic [6:0] a;
         logic       rw, hit;
         logic [7:0] idx, dat;
         int         r;
         a   = ($urandom % 6 == 0) ? 7'($urandom) : ADDR;
         rw  = ($urandom % 8 == 0);
         r   = $urandom % 6;
         idx = (r == 0 || r == 3) ? 8'h00 : (r == 1) ? 8'h04 : (r == 2) ? 8'h05 : 8'($urandom);
         dat = (idx == 8'h00) ? 8'($urandom % 9) : 8'($urandom);
         sys_awake = 1'($urandom);
         hit = (a == ADDR) && !rw;
         write_frame(a, rw, idx, dat, aa, ac, ad);
         if (hit) model_write(idx, dat, sys_awake);
         chk("R1 random addr ack", aa, hit);
         if (hit) chk("R2 random acks", {ac, ad}, 2'b11);
         check_all();
         if ($urandom % 5 == 0) clear_sts();
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
      $finish;
   end
endmodule